// File: doc/BRIEF.md
# Power Partition Gate and Clamp Controller

This block keeps the power and isolation state of up to 32 switchable power partitions. Software drives it through a small word-addressed write port and a combinational read port. Power is never set or cleared by bitmap. Each command names a single partition and flips its state, and the command takes effect only when it carries an explicit start flag. Two read-only registers report the state: one gives the power bit of every partition, the other gives its isolation clamp.

Isolation clamps start asserted. A one-hot release mask clears a clamp. The way mask bits map to partitions depends on a build-time mode:

- **Legacy mode.** The mask bits for the video-decode partition (ID 3) and the PCIe partition (ID 4) are crossed over.
- **Graphics-owned mode.** The graphics partition (ID 1) ignores the mask. Its clamp is driven only through its own control register. No bits are crossed over in this mode.

Whenever a partition loses power, its clamp comes back on automatically. The outputs are a power-enable vector and a clamp vector, one bit per partition, intended for the power switches and isolation cells.

Top module: `pgate_ctrl`

## Requirements
- R1: After synchronous reset, every power-enable bit is 0 and every clamp bit is 1.
- R2: A write to address 0 with data bit 8 set flips the power bit of the partition whose ID is in data bits 4:0. The new state is visible on `pwr_en` after the clock edge that takes the write.
- R3: A write to address 0 with data bit 8 clear changes no power or clamp bit.
- R4: A toggle whose ID is at or above `NUM_PART` changes no power or clamp bit.
- R5: Reading address 3 returns the power vector, with bit n set when partition n is powered. Reading address 4 returns the clamp vector. Every other read address returns 0.
- R6: A write to address 1 clears the clamp of each partition selected by a set mask bit. For partitions other than IDs 1, 3 and 4, mask bit n selects partition n in both modes. Mask bits at or above `NUM_PART` have no effect.
- R7: In legacy mode (`GFX_OWN_CLAMP`=0), mask bit 3 releases partition 4, mask bit 4 releases partition 3, and mask bit 1 releases partition 1. Writes to address 2 have no effect.
- R8: In graphics-owned mode (`GFX_OWN_CLAMP`=1), mask bit 1 has no effect and mask bits 3 and 4 release partitions 3 and 4 directly. A write of 0 to address 2 releases the clamp of partition 1. A nonzero write to address 2 asserts that clamp again.
- R9: A toggle that turns a partition off sets that partition's clamp on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data, combinational |
| pwr_en | output | NUM_PART | Power enable per partition |
| clamp_en | output | NUM_PART | Isolation clamp asserted per partition |

## Verification
The hardest case to reach is a clamp coming back on by itself. It only shows up after a partition has been powered, had its clamp released through the mode-specific mask mapping, and then been toggled off. The stimulus therefore powers partitions 1, 3 and 4 and releases their clamps through the crossed mask bits in legacy mode, and through the dedicated register in graphics-owned mode. It then toggles partitions 3 and 1 back off and reads the clamp vector. The bench drives two instances, one per mode, from the same write port. Because both see identical writes, any difference in their clamp vectors traces directly to the mode-specific mapping.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 32;
    localparam int ID_W      = 5;
    localparam int START_BIT = 8;

    localparam int PID_GFX  = 1;
    localparam int PID_VDEC = 3;
    localparam int PID_PCIE = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_TOGGLE     = 3'd0,
        REG_CLAMP_REL  = 3'd1,
        REG_GFX_CLAMP  = 3'd2,
        REG_PWR_STAT   = 3'd3,
        REG_CLAMP_STAT = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } toggle_cmd_t;

    typedef struct packed {
        logic              rel_valid;
        logic [DATA_W-1:0] mask;
        logic              gfx_valid;
        logic              gfx_release;
    } clamp_cmd_t;

    // Mask bit that releases partition pid.
    function automatic int mask_src(input int pid, input bit legacy);
        if (legacy && pid == PID_VDEC) return PID_PCIE;
        if (legacy && pid == PID_PCIE) return PID_VDEC;
        return pid;
    endfunction
endpackage

// File: rtl/pgate_decode.sv
module pgate_decode
    import pgate_pkg::*;
#(
    parameter int NUM_PART = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output toggle_cmd_t       tgl_cmd,
    output clamp_cmd_t        clp_cmd
);
    localparam logic [ID_W:0] ID_LIMIT = (ID_W+1)'(NUM_PART);

    logic [ID_W-1:0] id_field;
    logic            id_ok;

    assign id_field = wr_data[ID_W-1:0];
    assign id_ok    = {1'b0, id_field} < ID_LIMIT;

    always_comb begin
        tgl_cmd.valid = wr_en && (reg_addr_e'(wr_addr) == REG_TOGGLE)
                        && wr_data[START_BIT] && id_ok;
        tgl_cmd.id    = id_field;

        clp_cmd.rel_valid   = wr_en && (reg_addr_e'(wr_addr) == REG_CLAMP_REL);
        clp_cmd.mask        = wr_data;
        clp_cmd.gfx_valid   = wr_en && (reg_addr_e'(wr_addr) == REG_GFX_CLAMP);
        clp_cmd.gfx_release = (wr_data == '0);
    end
endmodule

// File: rtl/pgate_power.sv
module pgate_power
    import pgate_pkg::*;
#(
    parameter int NUM_PART = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  toggle_cmd_t         tgl_cmd,
    output logic [NUM_PART-1:0] pwr_q,
    output logic [NUM_PART-1:0] off_evt
);
    logic [NUM_PART-1:0] sel;

    always_comb begin
        sel = '0;
        if (tgl_cmd.valid) sel[tgl_cmd.id] = 1'b1;
    end

    // Partitions that are powered and about to flip off.
    assign off_evt = sel & pwr_q;

    always_ff @(posedge clk) begin
        if (rst) pwr_q <= '0;
        else     pwr_q <= pwr_q ^ sel;
    end
endmodule

// File: rtl/pgate_clamp.sv
module pgate_clamp
    import pgate_pkg::*;
#(
    parameter int NUM_PART      = 8,
    parameter bit GFX_OWN_CLAMP = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  clamp_cmd_t          clp_cmd,
    input  logic [NUM_PART-1:0] off_evt,
    output logic [NUM_PART-1:0] clamp_q
);
    for (genvar p = 0; p < NUM_PART; p++) begin : g_part
        if (GFX_OWN_CLAMP && p == PID_GFX) begin : g_gfx
            always_ff @(posedge clk) begin
                if (rst)                    clamp_q[p] <= 1'b1;
                else if (off_evt[p])        clamp_q[p] <= 1'b1;
                else if (clp_cmd.gfx_valid) clamp_q[p] <= !clp_cmd.gfx_release;
            end
        end else begin : g_mask
            localparam int SRC = mask_src(p, !GFX_OWN_CLAMP);
            always_ff @(posedge clk) begin
                if (rst)                clamp_q[p] <= 1'b1;
                else if (off_evt[p])    clamp_q[p] <= 1'b1;
                else if (clp_cmd.rel_valid && clp_cmd.mask[SRC])
                                        clamp_q[p] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
    import pgate_pkg::*;
#(
    parameter int NUM_PART      = 8,
    parameter bit GFX_OWN_CLAMP = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [31:0]         wr_data,
    input  logic [2:0]          rd_addr,
    output logic [31:0]         rd_data,
    output logic [NUM_PART-1:0] pwr_en,
    output logic [NUM_PART-1:0] clamp_en
);
    toggle_cmd_t         tgl_cmd;
    clamp_cmd_t          clp_cmd;
    logic [NUM_PART-1:0] off_evt;

    pgate_decode #(.NUM_PART(NUM_PART)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tgl_cmd (tgl_cmd),
        .clp_cmd (clp_cmd)
    );

    pgate_power #(.NUM_PART(NUM_PART)) u_power (
        .clk     (clk),
        .rst     (rst),
        .tgl_cmd (tgl_cmd),
        .pwr_q   (pwr_en),
        .off_evt (off_evt)
    );

    pgate_clamp #(.NUM_PART(NUM_PART), .GFX_OWN_CLAMP(GFX_OWN_CLAMP)) u_clamp (
        .clk     (clk),
        .rst     (rst),
        .clp_cmd (clp_cmd),
        .off_evt (off_evt),
        .clamp_q (clamp_en)
    );

    always_comb begin
        case (reg_addr_e'(rd_addr))
            REG_PWR_STAT:   rd_data = 32'(pwr_en);
            REG_CLAMP_STAT: rd_data = 32'(clamp_en);
            default:        rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pgate_ctrl_chk.sv
module pgate_ctrl_chk #(
    parameter int NUM_PART = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [2:0]          wr_addr,
    input logic [31:0]         wr_data,
    input logic [NUM_PART-1:0] pwr_en,
    input logic [NUM_PART-1:0] clamp_en
);
    logic [NUM_PART-1:0] tgl_mask;
    logic                tgl_wr;
    logic                id_in_range;

    assign tgl_mask    = {{(NUM_PART-1){1'b0}}, 1'b1} << wr_data[4:0];
    assign tgl_wr      = wr_en && (wr_addr == 3'd0);
    assign id_in_range = {27'd0, wr_data[4:0]} < 32'(NUM_PART);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (pwr_en == '0) && (clamp_en == '1));

    p_toggle_flip_r2: assert property (@(posedge clk) disable iff (rst)
        (tgl_wr && wr_data[8] && id_in_range) |=> (pwr_en == ($past(pwr_en) ^ $past(tgl_mask))));

    p_no_start_r3: assert property (@(posedge clk) disable iff (rst)
        (tgl_wr && !wr_data[8]) |=> ($stable(pwr_en) && $stable(clamp_en)));

    p_bad_id_r4: assert property (@(posedge clk) disable iff (rst)
        (tgl_wr && !id_in_range) |=> ($stable(pwr_en) && $stable(clamp_en)));

    p_single_flip_r2: assert property (@(posedge clk) disable iff (rst)
        ##1 ($countones(pwr_en ^ $past(pwr_en)) <= 1));

    p_off_reclamp_r9: assert property (@(posedge clk) disable iff (rst)
        ##1 ((($past(pwr_en) & ~pwr_en) & ~clamp_en) == '0));
endmodule

bind pgate_ctrl pgate_ctrl_chk #(.NUM_PART(NUM_PART)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pwr_en   (pwr_en),
    .clamp_en (clamp_en)
);

// File: tb/pgate_ctrl_tb.sv
module pgate_ctrl_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [31:0]  rd_l, rd_d;
    logic [N-1:0] pwr_l, pwr_d, clp_l, clp_d;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    // Legacy crossed-mask mode
    pgate_ctrl #(.NUM_PART(N), .GFX_OWN_CLAMP(1'b0)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_l), .pwr_en(pwr_l), .clamp_en(clp_l));

    // Graphics-owned clamp mode
    pgate_ctrl #(.NUM_PART(N), .GFX_OWN_CLAMP(1'b1)) u_dut_gfx (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_d), .pwr_en(pwr_d), .clamp_en(clp_d));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives at the falling edge; the result is visible at the following falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic expect_state(input string req, input logic [7:0] pl, input logic [7:0] cl,
                                input logic [7:0] pd, input logic [7:0] cd);
        rd_addr = 3'd3; #1;
        check({req, " legacy pwr"}, rd_l, 32'(pl));
        check({req, " gfxown pwr"}, rd_d, 32'(pd));
        rd_addr = 3'd4; #1;
        check({req, " legacy clamp"}, rd_l, 32'(cl));
        check({req, " gfxown clamp"}, rd_d, 32'(cd));
        check({req, " legacy pin"}, 32'(clp_l), 32'(cl));
        check({req, " gfxown pin"}, 32'(pwr_d), 32'(pd));
    endtask

    task automatic t_reset_r1;
        expect_state("R1", 8'h00, 8'hFF, 8'h00, 8'hFF);
    endtask

    task automatic t_toggle_r2;
        wr(3'd0, 32'h103);
        expect_state("R2", 8'h08, 8'hFF, 8'h08, 8'hFF);
        wr(3'd0, 32'h104);
        wr(3'd0, 32'h101);
        expect_state("R2", 8'h1A, 8'hFF, 8'h1A, 8'hFF);
    endtask

    task automatic t_no_start_r3;
        wr(3'd0, 32'h003);
        expect_state("R3", 8'h1A, 8'hFF, 8'h1A, 8'hFF);
    endtask

    task automatic t_bad_id_r4;
        wr(3'd0, 32'h109);
        wr(3'd0, 32'h11F);
        wr(3'd0, 32'h108);
        expect_state("R4", 8'h1A, 8'hFF, 8'h1A, 8'hFF);
    endtask

    task automatic t_readmap_r5;
        rd_addr = 3'd7; #1;
        check("R5 unmapped legacy", rd_l, 32'h0);
        check("R5 unmapped gfxown", rd_d, 32'h0);
        rd_addr = 3'd0; #1;
        check("R5 toggle addr reads 0", rd_l, 32'h0);
    endtask

    task automatic t_release_r6_r7_r8;
        wr(3'd1, 32'h100);                       // beyond NUM_PART: R6
        expect_state("R6", 8'h1A, 8'hFF, 8'h1A, 8'hFF);
        wr(3'd1, 32'h10);                        // R7 crossed / R8 direct
        expect_state("R7 R8", 8'h1A, 8'hF7, 8'h1A, 8'hEF);
        wr(3'd1, 32'h08);
        expect_state("R7 R8", 8'h1A, 8'hE7, 8'h1A, 8'hE7);
        wr(3'd1, 32'h04);                        // R6 plain bit
        expect_state("R6", 8'h1A, 8'hE3, 8'h1A, 8'hE3);
        wr(3'd1, 32'h02);                        // R7 releases, R8 ignores
        expect_state("R7 R8", 8'h1A, 8'hE1, 8'h1A, 8'hE3);
    endtask

    task automatic t_gfx_reg_r7_r8;
        wr(3'd2, 32'h0);
        expect_state("R7 R8 gfx release", 8'h1A, 8'hE1, 8'h1A, 8'hE1);
        wr(3'd2, 32'h7);
        expect_state("R7 R8 gfx reassert", 8'h1A, 8'hE1, 8'h1A, 8'hE3);
        wr(3'd2, 32'h0);
        expect_state("R8 gfx release again", 8'h1A, 8'hE1, 8'h1A, 8'hE1);
    endtask

    task automatic t_off_reclamp_r9;
        wr(3'd0, 32'h103);
        expect_state("R9", 8'h12, 8'hE9, 8'h12, 8'hE9);
        wr(3'd0, 32'h101);
        expect_state("R9", 8'h10, 8'hEB, 8'h10, 8'hEB);
        wr(3'd0, 32'h101);                       // power on does not release clamp
        expect_state("R2 R9", 8'h12, 8'hEB, 8'h12, 8'hEB);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset_r1();
                t_toggle_r2();
                t_no_start_r3();
                t_bad_id_r4();
                t_readmap_r5();
                t_release_r6_r7_r8();
                t_gfx_reg_r7_r8();
                t_off_reclamp_r9();
            end
            begin
                repeat (5000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule